// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block is a small bank of 32-bit control and status registers on a simple word-addressed bus. The bus has a read strobe, a write strobe, write data, registered read data and an access-error flag. Every word address belongs to one access class: read-write, read-only, write-only or unmapped. An access that breaks its class produces a one-cycle error pulse and leaves every register untouched.

The bank starts out locked. While it is locked, writes to the read-write registers are silently dropped. Two write-only key registers lock and unlock it. Each checks a 16-bit key in the low half of the written word, and a read-only status word shows the current lock state.

The bank holds a representative subset of controls: three PLL control words, a UART clock control, a system control bit, a reset control word and some status words. A write that sets bit 0 of the reset control word, accepted while the bank is unlocked, sends out a one-cycle system-reset request.

Top module: `keyed_reg_bank`

## Requirements
- R1: After reset the registers read as follows. Lock status (word 3) is 1. Each PLL control (words 4, 5, 6) is 0x0001A008. PLL status (word 7) is 0x0000003F. UART clock control (word 8) is 0x00003F03. Boot mode (word 10) is 0x00000001. System control (word 0) and reset control (word 9) are 0. Between reset and the first read, rdData, accErr and sysRstReq are 0.
- R2: A write to word 1 whose low 16 bits are 0x767B sets the lock status to 1, whatever the upper 16 bits hold. A write to word 1 with any other low half leaves the lock status unchanged.
- R3: A write to word 2 whose low 16 bits are 0xDF0D clears the lock status to 0, whatever the upper 16 bits hold. A write to word 2 with any other low half leaves the lock status unchanged.
- R4: While the bank is locked, a write to a read-write register (words 0, 4-6, 8, 9) changes nothing and raises no error. Writes to words 1 and 2 are still acted on.
- R5: The access classes are as follows. Words 0, 4, 5, 6, 8 and 9 are read-write. Words 3, 7, 10 and 11 are read-only. Words 1, 2, 12 and 13 are write-only. Every other word address is unmapped. Reading a write-only or unmapped word, or writing a read-only or unmapped word, sets accErr for exactly one cycle, on the clock edge that follows the access, and this holds whether or not the bank is locked. A rejected write changes no register.
- R6: Read data is registered and appears on the clock edge that follows the read strobe. Reads of write-only or unmapped words return 0. Writes to the write-only words 12 and 13 are accepted without error and store nothing.
- R7: A write to system control (word 0) stores only bit 0. The word reads back with bits 31:1 at zero.
- R8: An accepted write to reset control (word 9) with bit 0 set raises sysRstReq for one cycle on the following clock edge. A write with bit 0 clear raises no request, and neither does any write made while the bank is locked.
- R9: The identification word (word 11) reads as the ID_CODE parameter, which defaults to 0x1A5C0093.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordAddr | input | ADDR_W (10) | Word address of the access |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data, one cycle after rdEn |
| accErr | output | 1 | One-cycle pulse for an access that breaks its class |
| sysRstReq | output | 1 | One-cycle system-reset request |

## Verification
The bench targets the key compare. It tries near-miss keys, which a loose compare would accept and so lock or unlock on the wrong value. It also tries correct keys with junk in the upper half, which a full-word compare would reject.

Writes are sent to the read-write registers while the bank is locked, to catch a lock gate that lets them through. Writes are sent to read-only words and then read back, so a decode that lets a read-only register be overwritten shows up.

Reads of write-only and unmapped words are checked for zero data and for an error pulse exactly one cycle long. The reset request is exercised with bit 0 set, with bit 0 clear and while locked, which exposes a request that fires on any write or that ignores the lock.

// File: rtl/krb_pkg.sv
`timescale 1ns/1ps
package krb_pkg;
  localparam int WORD_W     = 32;
  localparam int KEY_W      = 16;
  localparam logic [KEY_W-1:0] LOCK_KEY   = 16'h767B;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D;

  localparam int PLL_CNT     = 3;
  localparam int IDX_SYS     = 0;
  localparam int IDX_LOCK    = 1;
  localparam int IDX_UNLOCK  = 2;
  localparam int IDX_LOCKSTA = 3;
  localparam int IDX_PLL0    = 4;
  localparam int IDX_PLLSTA  = IDX_PLL0 + PLL_CNT;
  localparam int IDX_UART    = IDX_PLLSTA + 1;
  localparam int IDX_RST     = IDX_UART + 1;
  localparam int IDX_BOOT    = IDX_RST + 1;
  localparam int IDX_ID      = IDX_BOOT + 1;
  localparam int IDX_CAL     = IDX_ID + 1;
  localparam int IDX_REF     = IDX_CAL + 1;

  localparam logic [WORD_W-1:0] PLL_RST_VAL    = 32'h0001_A008;
  localparam logic [WORD_W-1:0] PLLSTA_VAL     = 32'h0000_003F;
  localparam logic [WORD_W-1:0] UART_RST_VAL   = 32'h0000_3F03;
  localparam logic [WORD_W-1:0] BOOT_VAL       = 32'h0000_0001;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_e;

  // Strobes from the decode/control side to the register datapath.
  typedef struct packed {
    logic               wrSys;
    logic [PLL_CNT-1:0] wrPll;
    logic               wrUart;
    logic               wrRst;
    logic               setLock;
    logic               clrLock;
    logic               rdLoad;
    logic               rdZero;
    logic               err;
    logic               rstReq;
  } strobe_t;

  function automatic acc_e classOf(input int unsigned idx);
    if (idx >= IDX_PLL0 && idx < IDX_PLL0 + PLL_CNT) return ACC_RW;
    case (idx)
      IDX_SYS, IDX_UART, IDX_RST:              return ACC_RW;
      IDX_LOCKSTA, IDX_PLLSTA, IDX_BOOT, IDX_ID: return ACC_RO;
      IDX_LOCK, IDX_UNLOCK, IDX_CAL, IDX_REF:  return ACC_WO;
      default:                                 return ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/krb_ctrl.sv
`timescale 1ns/1ps
module krb_ctrl
  import krb_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [KEY_W-1:0] keyLow,
  input  logic             wrBit0,
  input  logic             locked,
  output strobe_t          stb
);
  acc_e cls;
  logic rdOk;
  logic wrLegal;
  logic wrGo;

  always_comb begin
    cls     = classOf(32'(wordIdx));
    rdOk    = rdEn && (cls == ACC_RW || cls == ACC_RO);
    wrLegal = wrEn && (cls == ACC_RW || cls == ACC_WO);
    wrGo    = wrLegal && !locked && (cls == ACC_RW);
  end

  always_comb begin
    stb = '0;
    stb.err     = (rdEn && !rdOk) || (wrEn && !wrLegal);
    stb.rdLoad  = rdEn;
    stb.rdZero  = !rdOk;
    stb.setLock = wrLegal && (wordIdx == IDX_W'(IDX_LOCK)) && (keyLow == LOCK_KEY);
    stb.clrLock = wrLegal && (wordIdx == IDX_W'(IDX_UNLOCK)) && (keyLow == UNLOCK_KEY);
    stb.wrSys   = wrGo && (wordIdx == IDX_W'(IDX_SYS));
    stb.wrUart  = wrGo && (wordIdx == IDX_W'(IDX_UART));
    stb.wrRst   = wrGo && (wordIdx == IDX_W'(IDX_RST));
    stb.rstReq  = wrGo && (wordIdx == IDX_W'(IDX_RST)) && wrBit0;
    for (int i = 0; i < PLL_CNT; i++) begin
      stb.wrPll[i] = wrGo && (wordIdx == IDX_W'(IDX_PLL0 + i));
    end
  end
endmodule

// File: rtl/krb_datapath.sv
`timescale 1ns/1ps
module krb_datapath
  import krb_pkg::*;
#(
  parameter int                IDX_W   = 10,
  parameter logic [WORD_W-1:0] ID_CODE = 32'h1A5C_0093
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [WORD_W-1:0] wrData,
  output logic              locked,
  output logic [WORD_W-1:0] rdData,
  output logic              accErr,
  output logic              sysRstReq
);
  logic              sysBit;
  logic [WORD_W-1:0] uartCtrl;
  logic [WORD_W-1:0] rstCtrl;
  logic [WORD_W-1:0] pllCtrl [PLL_CNT];
  logic [WORD_W-1:0] rdNext;

  genvar g;
  for (g = 0; g < PLL_CNT; g++) begin : g_pll
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)             q <= PLL_RST_VAL;
      else if (stb.wrPll[g]) q <= wrData;
    end
    assign pllCtrl[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysBit   <= 1'b0;
      uartCtrl <= UART_RST_VAL;
      rstCtrl  <= '0;
      locked   <= 1'b1;
    end else begin
      if (stb.wrSys)   sysBit   <= wrData[0];
      if (stb.wrUart)  uartCtrl <= wrData;
      if (stb.wrRst)   rstCtrl  <= wrData;
      if (stb.setLock)      locked <= 1'b1;
      else if (stb.clrLock) locked <= 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    if (!stb.rdZero) begin
      case (rdIdx)
        IDX_W'(IDX_SYS):     rdNext = {{(WORD_W-1){1'b0}}, sysBit};
        IDX_W'(IDX_LOCKSTA): rdNext = {{(WORD_W-1){1'b0}}, locked};
        IDX_W'(IDX_PLLSTA):  rdNext = PLLSTA_VAL;
        IDX_W'(IDX_UART):    rdNext = uartCtrl;
        IDX_W'(IDX_RST):     rdNext = rstCtrl;
        IDX_W'(IDX_BOOT):    rdNext = BOOT_VAL;
        IDX_W'(IDX_ID):      rdNext = ID_CODE;
        default:             rdNext = '0;
      endcase
      for (int i = 0; i < PLL_CNT; i++) begin
        if (rdIdx == IDX_W'(IDX_PLL0 + i)) rdNext = pllCtrl[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      accErr    <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      if (stb.rdLoad) rdData <= rdNext;
      accErr    <= stb.err;
      sysRstReq <= stb.rstReq;
    end
  end
endmodule

// File: rtl/keyed_reg_bank.sv
`timescale 1ns/1ps
module keyed_reg_bank
  import krb_pkg::*;
#(
  parameter int                ADDR_W  = 10,
  parameter logic [WORD_W-1:0] ID_CODE = 32'h1A5C_0093
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              accErr,
  output logic              sysRstReq
);
  strobe_t stb;
  logic    locked;

  krb_ctrl #(.IDX_W(ADDR_W)) i_ctrl (
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .wordIdx (wordAddr),
    .keyLow  (wrData[KEY_W-1:0]),
    .wrBit0  (wrData[0]),
    .locked  (locked),
    .stb     (stb)
  );

  krb_datapath #(.IDX_W(ADDR_W), .ID_CODE(ID_CODE)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdIdx     (wordAddr),
    .wrData    (wrData),
    .locked    (locked),
    .rdData    (rdData),
    .accErr    (accErr),
    .sysRstReq (sysRstReq)
  );
endmodule

// File: rtl/krb_chk.sv
`timescale 1ns/1ps
module krb_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] wordAddr,
  input logic              rdEn,
  input logic              wrEn,
  input logic [15:0]       keyLow,
  input logic [31:0]       rdData,
  input logic              accErr,
  input logic              sysRstReq,
  input logic              locked
);
  // R5
  err_has_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(rdEn || wrEn));

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);

  // R8
  rst_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> ($past(wrEn) && !$past(locked)));

  // R2
  lock_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordAddr == ADDR_W'(1) && keyLow == 16'h767B) |=> locked);

  // R3
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordAddr == ADDR_W'(2) && keyLow == 16'hDF0D) |=> !locked);

  // R6
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (wordAddr == ADDR_W'(1) || wordAddr == ADDR_W'(2))) |=> (rdData == 32'd0 && accErr));

  // R4
  lock_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(locked) |-> $past(wrEn));
endmodule

bind keyed_reg_bank krb_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wordAddr  (wordAddr),
  .rdEn      (rdEn),
  .wrEn      (wrEn),
  .keyLow    (wrData[15:0]),
  .rdData    (rdData),
  .accErr    (accErr),
  .sysRstReq (sysRstReq),
  .locked    (locked)
);

// File: tb/test_keyed_reg_bank.sv
`timescale 1ns/1ps
module test_keyed_reg_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  wordAddr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        accErr;
  logic        sysRstReq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] sRd;
  logic        sErr;
  logic        sReq;

  always #2.5 clk = ~clk;

  keyed_reg_bank i_keyed_reg_bank (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .accErr(accErr), .sysRstReq(sysRstReq)
  );

  typedef struct packed {
    logic        isWr;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] expRd;
    logic        expErr;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd3,  32'h0,         32'h1,         1'b0, "R1"},
    '{1'b0, 10'd4,  32'h0,         32'h0001A008,  1'b0, "R1"},
    '{1'b0, 10'd7,  32'h0,         32'h0000003F,  1'b0, "R1"},
    '{1'b0, 10'd8,  32'h0,         32'h00003F03,  1'b0, "R1"},
    '{1'b0, 10'd10, 32'h0,         32'h00000001,  1'b0, "R1"},
    '{1'b0, 10'd11, 32'h0,         32'h1A5C0093,  1'b0, "R9"},
    '{1'b1, 10'd4,  32'h12345678,  32'h0,         1'b0, "R4"},
    '{1'b0, 10'd4,  32'h0,         32'h0001A008,  1'b0, "R4"},
    '{1'b1, 10'd2,  32'h0000DF0C,  32'h0,         1'b0, "R3"},
    '{1'b0, 10'd3,  32'h0,         32'h1,         1'b0, "R3"},
    '{1'b1, 10'd2,  32'hFFFFDF0D,  32'h0,         1'b0, "R3"},
    '{1'b0, 10'd3,  32'h0,         32'h0,         1'b0, "R3"},
    '{1'b1, 10'd5,  32'h12345678,  32'h0,         1'b0, "R4"},
    '{1'b0, 10'd5,  32'h0,         32'h12345678,  1'b0, "R4"},
    '{1'b1, 10'd0,  32'hFFFFFFFF,  32'h0,         1'b0, "R7"},
    '{1'b0, 10'd0,  32'h0,         32'h1,         1'b0, "R7"},
    '{1'b0, 10'd1,  32'h0,         32'h0,         1'b1, "R6"},
    '{1'b0, 10'h40, 32'h0,         32'h0,         1'b1, "R5"},
    '{1'b1, 10'd7,  32'h0,         32'h0,         1'b1, "R5"},
    '{1'b0, 10'd7,  32'h0,         32'h0000003F,  1'b0, "R5"},
    '{1'b1, 10'd12, 32'h5,         32'h0,         1'b0, "R6"},
    '{1'b0, 10'd12, 32'h0,         32'h0,         1'b1, "R6"},
    '{1'b1, 10'd1,  32'h0000767A,  32'h0,         1'b0, "R2"},
    '{1'b0, 10'd3,  32'h0,         32'h0,         1'b0, "R2"},
    '{1'b1, 10'd1,  32'hABCD767B,  32'h0,         1'b0, "R2"},
    '{1'b0, 10'd3,  32'h0,         32'h1,         1'b0, "R2"},
    '{1'b1, 10'd6,  32'h0000AAAA,  32'h0,         1'b0, "R4"},
    '{1'b0, 10'd6,  32'h0,         32'h0001A008,  1'b0, "R4"}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs sampled.
  task automatic doAcc(input logic w, input logic [9:0] a, input logic [31:0] d);
    wordAddr = a;
    wrData   = d;
    wrEn     = w;
    rdEn     = !w;
    @(negedge clk);
    wrEn = 1'b0;
    rdEn = 1'b0;
    sRd  = rdData;
    sErr = accErr;
    sReq = sysRstReq;
  endtask

  task automatic idle();
    @(negedge clk);
    sRd  = rdData;
    sErr = accErr;
    sReq = sysRstReq;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R1: quiet outputs after reset
    chk("R1 rdData", sRd, 32'h0);
    chk("R1 accErr", {31'd0, sErr}, 32'h0);
    chk("R1 sysRstReq", {31'd0, sReq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      doAcc(VECS[i].isWr, VECS[i].a, VECS[i].d);
      chk($sformatf("%s err v%0d", VECS[i].tag, i), {31'd0, sErr}, {31'd0, VECS[i].expErr});
      if (!VECS[i].isWr)
        chk($sformatf("%s rd v%0d", VECS[i].tag, i), sRd, VECS[i].expRd);
      chk($sformatf("R8 noreq v%0d", i), {31'd0, sReq}, 32'h0);
    end

    // R5: error lasts exactly one cycle
    doAcc(1'b0, 10'd2, 32'h0);
    chk("R5 err pulse", {31'd0, sErr}, 32'h1);
    idle();
    chk("R5 err clears", {31'd0, sErr}, 32'h0);
    // R5: unmapped write while locked still errors
    doAcc(1'b1, 10'h3FF, 32'h1);
    chk("R5 locked unmapped wr", {31'd0, sErr}, 32'h1);

    // R8: reset request
    doAcc(1'b1, 10'd2, 32'h0000DF0D);
    doAcc(1'b1, 10'd9, 32'h00000001);
    chk("R8 req raised", {31'd0, sReq}, 32'h1);
    idle();
    chk("R8 req one cycle", {31'd0, sReq}, 32'h0);
    doAcc(1'b0, 10'd9, 32'h0);
    chk("R8 rst ctrl stored", sRd, 32'h1);
    doAcc(1'b1, 10'd9, 32'h00000002);
    chk("R8 bit0 clear no req", {31'd0, sReq}, 32'h0);
    doAcc(1'b1, 10'd1, 32'h0000767B);
    doAcc(1'b1, 10'd9, 32'h00000001);
    chk("R8 locked no req", {31'd0, sReq}, 32'h0);
    doAcc(1'b0, 10'd9, 32'h0);
    chk("R4 locked rst ctrl kept", sRd, 32'h2);
    // R6: read data holds when no read is issued
    idle();
    chk("R6 rdData holds", sRd, 32'h2);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule